// File: doc/BRIEF.md
# Status-Decoded Bus Command Controller

This block sits beside a processor that reports each bus cycle as a 3-bit status code. It turns that code into the strobes the rest of the system needs: an address latch pulse, the data direction and data enable for the transceivers, active-low memory and I/O read and write commands, early write commands for slow devices, and an interrupt acknowledge. It follows each bus cycle through the clock states T1, T2, T3 and T4. When the ready input has not come high in time, it adds wait states between T3 and T4.

Three static control inputs shape the outputs. One enables all commands. An active-low address-enable lets the memory commands through. A mode input selects I/O-bus operation, and that choice sets the meaning of a dual-purpose enable output. For a single-processor system, tie the address enable and the mode input low and the command enable high.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While synchronous reset is high, and on the first edge after it clears with passive status, ale=0, den=0, dt_r=1, mce_pden=0, and all seven active-low commands are 1.
- R2: A cycle starts on the rising edge at which status is not 111 and not 011, the status sampled on the previous edge was 111, and the tracker is idle or in T4. The outputs after that edge show T1. ale is high only in T1, for exactly one clock per cycle.
- R3: For codes 000, 001, 100 and 101, dt_r is 0 from T1 through T4. For write codes 010 and 110, and when idle, dt_r is 1.
- R4: den is 1 in T2, T3, every wait state and T4, and 0 in T1 and when idle.
- R5: Read-type commands are low from T2 through T4: mem_rd_n for 101 and 100, io_rd_n for 001, inta_n for 000. At most one of them is low at a time.
- R6: For 110, adv_mem_wr_n is low from T2 through T4 and mem_wr_n is low from T3 through T4. For 010, adv_io_wr_n and io_wr_n follow the same pattern. The normal write is never low without its advanced write.
- R7: ready is sampled on the edge that leaves T3 and on each edge that leaves a wait state. Each sample of 0 adds a wait state in which all active commands and den hold their values. T4 follows the first sample of 1.
- R8: Status changes after T1, including the return to 111 in T3 and a non-passive code during a wait state, start no new cycle.
- R9: Status 011 (halt) starts no cycle: ale, den and every command stay inactive.
- R10: When cmd_en was 0 at the previous edge, all seven commands are 1. ale, dt_r and den still sequence normally.
- R11: When addr_en_n was 1 at the previous edge, mem_rd_n, mem_wr_n and adv_mem_wr_n are 1. The I/O commands and inta_n still operate.
- R12: With iob_mode=1, mce_pden is 1 from T2 through T4 of codes 001 and 010. With iob_mode=0, it is 1 only in T1 of code 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| status | input | 3 | Processor bus status code, 111 is passive |
| ready | input | 1 | Ready input; 0 at the end of T3 adds a wait state |
| cmd_en | input | 1 | Command enable; 0 forces all commands inactive |
| addr_en_n | input | 1 | Address enable, active low; 1 blocks the memory commands |
| iob_mode | input | 1 | 1 selects I/O-bus mode |
| ale | output | 1 | Address latch enable pulse in T1 |
| dt_r | output | 1 | Data direction: 1 transmit, 0 receive |
| den | output | 1 | Data transceiver enable, active high |
| mce_pden | output | 1 | Cascade enable (iob_mode=0) or peripheral data enable (iob_mode=1) |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| adv_mem_wr_n | output | 1 | Advanced memory write command |
| adv_io_wr_n | output | 1 | Advanced I/O write command |
| inta_n | output | 1 | Interrupt acknowledge |

## Verification
The hardest case to reach is a status change that lands while a cycle is already under way. The clearest instance is a non-passive code arriving during a wait state, after the status has already gone back to 111. This is exactly the pattern that would make a careless edge detector start a second cycle. The stimulus reaches it in two steps. First it holds ready low at the end of T3, which opens a wait window. It then drives a memory-read code in the first wait clock and a different code during T2. The scoreboard expects the original cycle to finish unchanged.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

   typedef enum logic [2:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_TW   = 3'd4,
      TS_T4   = 3'd5
   } tstate_e;

   // status encoding is behavioural: it is what the processor drives
   typedef enum logic [2:0] {
      CY_INTA  = 3'b000,
      CY_IORD  = 3'b001,
      CY_IOWR  = 3'b010,
      CY_HALT  = 3'b011,
      CY_FETCH = 3'b100,
      CY_MRD   = 3'b101,
      CY_MWR   = 3'b110,
      CY_PASS  = 3'b111
   } cycle_e;

   // command vector slots
   localparam int CMD_MRD   = 0;
   localparam int CMD_MWR   = 1;
   localparam int CMD_IORD  = 2;
   localparam int CMD_IOWR  = 3;
   localparam int CMD_AMWR  = 4;
   localparam int CMD_AIOWR = 5;
   localparam int CMD_INTA  = 6;
   localparam int NCMD      = 7;

   function automatic bit is_mem_cmd(input int idx);
      return (idx == CMD_MRD) || (idx == CMD_MWR) || (idx == CMD_AMWR);
   endfunction

   function automatic bit is_read_code(input cycle_e c);
      return (c == CY_INTA) || (c == CY_IORD) || (c == CY_FETCH) || (c == CY_MRD);
   endfunction

endpackage

// File: rtl/bcc_tstate_fsm.sv
module bcc_tstate_fsm
   import bus_cmd_pkg::*;
#(
   parameter int STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STAT_W-1:0] status,
   input  logic              ready,
   output tstate_e           st_d,
   output cycle_e            code_d
);

   localparam logic [STAT_W-1:0] PASS_CODE = {STAT_W{1'b1}};

   initial assert (STAT_W == 3) else $error("bcc_tstate_fsm: STAT_W must be 3");

   tstate_e st_q;
   cycle_e  code_q;
   logic    prev_pass_q;
   logic    start;
   cycle_e  stat_c;

   assign stat_c = cycle_e'(status[2:0]);

   assign start = ((st_q == TS_IDLE) || (st_q == TS_T4)) && prev_pass_q &&
                  (status != PASS_CODE) && (stat_c != CY_HALT);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TS_IDLE: st_d = start ? TS_T1 : TS_IDLE;
         TS_T1:   st_d = TS_T2;
         TS_T2:   st_d = TS_T3;
         TS_T3:   st_d = ready ? TS_T4 : TS_TW;
         TS_TW:   st_d = ready ? TS_T4 : TS_TW;
         TS_T4:   st_d = start ? TS_T1 : TS_IDLE;
         default: st_d = TS_IDLE;
      endcase
      if (rst) st_d = TS_IDLE;
   end

   assign code_d = rst ? CY_PASS : (start ? stat_c : code_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q        <= TS_IDLE;
         code_q      <= CY_PASS;
         prev_pass_q <= 1'b1;
      end else begin
         st_q        <= st_d;
         code_q      <= code_d;
         prev_pass_q <= (status == PASS_CODE);
      end
   end

   // T4 is only reached after ready was seen high
   p_t4_needs_ready_r7: assert property (@(posedge clk) disable iff (rst)
      (st_q == TS_T4) |-> $past(ready));

   // a cycle in progress never restarts before T4
   p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
      (st_q == TS_T1) |=> (st_q == TS_T2));

endmodule

// File: rtl/bcc_cmd_stage.sv
module bcc_cmd_stage
   import bus_cmd_pkg::*;
#(
   parameter int NC = NCMD
) (
   input  logic          clk,
   input  logic          rst,
   input  tstate_e       st_d,
   input  cycle_e        code_d,
   input  logic          cmd_en,
   input  logic          addr_en_n,
   input  logic          iob_mode,
   output logic          ale_q,
   output logic          dt_r_q,
   output logic          den_q,
   output logic          mce_pden_q,
   output logic [NC-1:0] cmd_n_q
);

   initial assert (NC == NCMD) else $error("bcc_cmd_stage: NC must equal NCMD");

   logic          act_rd, act_wr, in_cyc;
   logic [NC-1:0] raw, gated;

   assign in_cyc = (st_d != TS_IDLE);
   assign act_rd = (st_d == TS_T2) || (st_d == TS_T3) || (st_d == TS_TW) || (st_d == TS_T4);
   assign act_wr = (st_d == TS_T3) || (st_d == TS_TW) || (st_d == TS_T4);

   always_comb begin
      raw            = '0;
      raw[CMD_MRD]   = act_rd && ((code_d == CY_MRD) || (code_d == CY_FETCH));
      raw[CMD_IORD]  = act_rd && (code_d == CY_IORD);
      raw[CMD_INTA]  = act_rd && (code_d == CY_INTA);
      raw[CMD_AMWR]  = act_rd && (code_d == CY_MWR);
      raw[CMD_AIOWR] = act_rd && (code_d == CY_IOWR);
      raw[CMD_MWR]   = act_wr && (code_d == CY_MWR);
      raw[CMD_IOWR]  = act_wr && (code_d == CY_IOWR);
   end

   for (genvar i = 0; i < NC; i++) begin : g_gate
      if (is_mem_cmd(i)) begin : g_mem
         assign gated[i] = raw[i] && cmd_en && !addr_en_n;
      end else begin : g_io
         assign gated[i] = raw[i] && cmd_en;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ale_q      <= 1'b0;
         dt_r_q     <= 1'b1;
         den_q      <= 1'b0;
         mce_pden_q <= 1'b0;
         cmd_n_q    <= '1;
      end else begin
         ale_q      <= (st_d == TS_T1);
         dt_r_q     <= !(in_cyc && is_read_code(code_d));
         den_q      <= act_rd;
         mce_pden_q <= iob_mode ? (act_rd && ((code_d == CY_IORD) || (code_d == CY_IOWR)))
                                : ((st_d == TS_T1) && (code_d == CY_INTA));
         cmd_n_q    <= ~gated;
      end
   end

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
   import bus_cmd_pkg::*;
#(
   parameter int STAT_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STAT_W-1:0] status,
   input  logic              ready,
   input  logic              cmd_en,
   input  logic              addr_en_n,
   input  logic              iob_mode,
   output logic              ale,
   output logic              dt_r,
   output logic              den,
   output logic              mce_pden,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              io_rd_n,
   output logic              io_wr_n,
   output logic              adv_mem_wr_n,
   output logic              adv_io_wr_n,
   output logic              inta_n
);

   tstate_e         st_d;
   cycle_e          code_d;
   logic [NCMD-1:0] cmd_n;

   bcc_tstate_fsm #(.STAT_W(STAT_W)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .status (status),
      .ready  (ready),
      .st_d   (st_d),
      .code_d (code_d)
   );

   bcc_cmd_stage #(.NC(NCMD)) u_cmd (
      .clk        (clk),
      .rst        (rst),
      .st_d       (st_d),
      .code_d     (code_d),
      .cmd_en     (cmd_en),
      .addr_en_n  (addr_en_n),
      .iob_mode   (iob_mode),
      .ale_q      (ale),
      .dt_r_q     (dt_r),
      .den_q      (den),
      .mce_pden_q (mce_pden),
      .cmd_n_q    (cmd_n)
   );

   assign mem_rd_n     = cmd_n[CMD_MRD];
   assign mem_wr_n     = cmd_n[CMD_MWR];
   assign io_rd_n      = cmd_n[CMD_IORD];
   assign io_wr_n      = cmd_n[CMD_IOWR];
   assign adv_mem_wr_n = cmd_n[CMD_AMWR];
   assign adv_io_wr_n  = cmd_n[CMD_AIOWR];
   assign inta_n       = cmd_n[CMD_INTA];

   p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
      ale |=> !ale);

   p_den_with_cmd_r4: assert property (@(posedge clk) disable iff (rst)
      (!mem_rd_n || !io_rd_n || !inta_n || !adv_mem_wr_n || !adv_io_wr_n) |-> den);

   p_one_read_r5: assert property (@(posedge clk) disable iff (rst)
      $countones({~mem_rd_n, ~io_rd_n, ~inta_n}) <= 1);

   p_mwr_has_adv_r6: assert property (@(posedge clk) disable iff (rst)
      !mem_wr_n |-> !adv_mem_wr_n);

   p_iowr_has_adv_r6: assert property (@(posedge clk) disable iff (rst)
      !io_wr_n |-> !adv_io_wr_n);

   p_cmd_gate_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(cmd_en) |-> (&cmd_n));

   p_mem_gate_r11: assert property (@(posedge clk) disable iff (rst)
      $past(addr_en_n) |-> (mem_rd_n && mem_wr_n && adv_mem_wr_n));

endmodule

// File: tb/bus_cmd_ctrl_bench.sv
module bus_cmd_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] status = 3'b111;
   logic       ready = 1'b1;
   logic       cmd_en = 1'b1;
   logic       addr_en_n = 1'b0;
   logic       iob_mode = 1'b0;
   logic ale, dt_r, den, mce_pden;
   logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, adv_mem_wr_n, adv_io_wr_n, inta_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench state names: 0 idle 1 T1 2 T2 3 T3 4 wait 5 T4
   localparam int S_ID = 0, S_T1 = 1, S_T2 = 2, S_T3 = 3, S_TW = 4, S_T4 = 5;

   logic [10:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   bus_cmd_ctrl u_bus_cmd_ctrl (
      .clk(clk), .rst(rst), .status(status), .ready(ready), .cmd_en(cmd_en),
      .addr_en_n(addr_en_n), .iob_mode(iob_mode), .ale(ale), .dt_r(dt_r), .den(den),
      .mce_pden(mce_pden), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
      .io_wr_n(io_wr_n), .adv_mem_wr_n(adv_mem_wr_n), .adv_io_wr_n(adv_io_wr_n),
      .inta_n(inta_n)
   );

   // expected {ale,dt_r,den,mce_pden,mem_rd_n,mem_wr_n,io_rd_n,io_wr_n,adv_mem_wr_n,adv_io_wr_n,inta_n}
   function automatic logic [10:0] expect_vec(input int ts, input logic [2:0] c);
      logic rd_win, wr_win, busy, rdcode, memok;
      logic a, d, e, m, mr, mw, ir, iw, amw, aiw, ia;
      busy   = (ts != S_ID);
      rd_win = (ts == S_T2) || (ts == S_T3) || (ts == S_TW) || (ts == S_T4);
      wr_win = (ts == S_T3) || (ts == S_TW) || (ts == S_T4);
      rdcode = (c == 3'b000) || (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
      memok  = cmd_en && !addr_en_n;
      a   = (ts == S_T1);
      d   = !(busy && rdcode);
      e   = rd_win;
      m   = iob_mode ? (rd_win && (c == 3'b001 || c == 3'b010)) : ((ts == S_T1) && c == 3'b000);
      mr  = !(memok && rd_win && (c == 3'b101 || c == 3'b100));
      mw  = !(memok && wr_win && c == 3'b110);
      amw = !(memok && rd_win && c == 3'b110);
      ir  = !(cmd_en && rd_win && c == 3'b001);
      iw  = !(cmd_en && wr_win && c == 3'b010);
      aiw = !(cmd_en && rd_win && c == 3'b010);
      ia  = !(cmd_en && rd_win && c == 3'b000);
      return {a, d, e, m, mr, mw, ir, iw, amw, aiw, ia};
   endfunction

   // driver: inputs for the coming edge, expectation for just after it
   task automatic step(input logic [2:0] s, input logic r, input int ts,
                       input logic [2:0] c, input string tag);
      @(negedge clk);
      status = s;
      ready  = r;
      exp_q.push_back(expect_vec(ts, c));
      tag_q.push_back(tag);
   endtask

   task automatic bus_cycle(input logic [2:0] c, input int nwait, input bit glitch,
                            input string tag);
      step(c, 1'b1, S_T1, c, tag);
      step(glitch ? 3'b100 : c, 1'b1, S_T2, c, tag);
      step(3'b111, 1'b1, S_T3, c, tag);
      for (int w = 0; w < nwait; w++)
         step((glitch && w == 0) ? 3'b101 : 3'b111, 1'b0, S_TW, c, tag);
      step(3'b111, 1'b1, S_T4, c, tag);
      step(3'b111, 1'b1, S_ID, c, tag);
   endtask

   // monitor: compare just after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [10:0] e;
            logic [10:0] got;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {ale, dt_r, den, mce_pden, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n,
                   adv_mem_wr_n, adv_io_wr_n, inta_n};
            checks++;
            if (got !== e) begin
               errors++;
               $display("FAIL %s actual %b expected %b at %0t", t, got, e, $time);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(3'b111, 1'b1, S_ID, 3'b111, "R1");
      step(3'b111, 1'b1, S_ID, 3'b111, "R1");
      @(negedge clk); rst = 1'b0;
      step(3'b111, 1'b1, S_ID, 3'b111, "R1");

      // R2 R3 R4 R5: memory read, code fetch, I/O read, interrupt acknowledge
      bus_cycle(3'b101, 0, 0, "R2_R5 mem read");
      bus_cycle(3'b100, 0, 0, "R5 fetch");
      bus_cycle(3'b000, 0, 0, "R3_R5 inta");
      // R7 wait states on a read
      bus_cycle(3'b001, 2, 0, "R7 io read waits");
      // R6 writes, with R7 wait
      bus_cycle(3'b110, 0, 0, "R6 mem write");
      bus_cycle(3'b010, 1, 0, "R6_R7 io write wait");
      bus_cycle(3'b110, 3, 0, "R4_R7 mem write waits");

      // R9 halt
      step(3'b011, 1'b1, S_ID, 3'b011, "R9 halt");
      step(3'b011, 1'b1, S_ID, 3'b011, "R9 halt");
      step(3'b011, 1'b1, S_ID, 3'b011, "R9 halt");
      step(3'b111, 1'b1, S_ID, 3'b111, "R9 halt");

      // R8 status changes inside a cycle
      bus_cycle(3'b101, 2, 1, "R8 mid-cycle status");
      bus_cycle(3'b010, 1, 1, "R8 mid-cycle status");

      // R10 command enable low
      @(negedge clk); cmd_en = 1'b0;
      step(3'b111, 1'b1, S_ID, 3'b111, "R10");
      bus_cycle(3'b110, 1, 0, "R10 gated write");
      bus_cycle(3'b001, 0, 0, "R10 gated io read");
      @(negedge clk); cmd_en = 1'b1;
      step(3'b111, 1'b1, S_ID, 3'b111, "R10");

      // R11 address enable inactive
      @(negedge clk); addr_en_n = 1'b1;
      step(3'b111, 1'b1, S_ID, 3'b111, "R11");
      bus_cycle(3'b101, 0, 0, "R11 mem read blocked");
      bus_cycle(3'b110, 0, 0, "R11 mem write blocked");
      bus_cycle(3'b001, 0, 0, "R11 io read passes");
      bus_cycle(3'b000, 0, 0, "R11 inta passes");
      @(negedge clk); addr_en_n = 1'b0;
      step(3'b111, 1'b1, S_ID, 3'b111, "R11");

      // R12 I/O-bus mode
      @(negedge clk); iob_mode = 1'b1;
      step(3'b111, 1'b1, S_ID, 3'b111, "R12");
      bus_cycle(3'b001, 1, 0, "R12 pden io read");
      bus_cycle(3'b010, 0, 0, "R12 pden io write");
      bus_cycle(3'b101, 0, 0, "R12 no pden mem");
      bus_cycle(3'b000, 0, 0, "R12 no mce in iob mode");
      @(negedge clk); iob_mode = 1'b0;
      step(3'b111, 1'b1, S_ID, 3'b111, "R12");

      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule